// File: doc/BRIEF.md
# Selectable-Length Pseudorandom Bit Generator

This block is a Fibonacci-style linear feedback shift register that emits a pseudorandom bit stream. A two-bit select chooses, at run time, one of three register lengths: 4, 8 or 16 bits. Each length has its own maximal-length feedback polynomial, so the stream repeats only after 2^n−1 advances. The feedback is the XOR of the tap stages of the active length. It enters stage 0, and the serial output comes from the last stage of that length.

The register advances only on clocks where the step enable is high. A synchronous reset and a separate seed-load strobe give two ways to fix the state. The register never holds all zeros. A zero seed is replaced by the value 1, and stages above the active length stay at zero. When the length select changes, the register restarts from the value 1 on the next clock. A one-cycle wrap pulse marks the return to the state the current run started from. An internal step counter confirms that this return comes after exactly one full period.

Top module: `lfsr_seqgen`

## Requirements
- R1: With select 2'b00 (4 bits), the next stage-0 value is state[3] XOR state[2], and the sequence repeats every 15 advances.
- R2: With select 2'b01 (8 bits), the next stage-0 value is state[7]^state[3]^state[2]^state[1] (x^8+x^4+x^3+x^2+1), and the sequence repeats every 255 advances.
- R3: With select 2'b10 or 2'b11 (16 bits), the next stage-0 value is state[15]^state[11]^state[2]^state[0] (x^16+x^12+x^3+x+1), and the sequence repeats every 65,535 advances.
- R4: On an advance, every stage i takes the old value of stage i−1. The serial output equals state[n−1] for the active length n.
- R5: When reset is high at a clock edge, the state becomes 16'h0001 after that edge, the wrap flag goes low, and the select value is latched as the active length.
- R6: When seed load is high, the state becomes the seed masked to the new length. If that masked seed is zero, the state becomes 16'h0001.
- R7: Priority runs from reset, to seed load, to a length-select change, to an advance.
- R8: When the select differs from the active length, with no reset or load, the next clock sets the state to 16'h0001 under the new length.
- R9: With step low and no reset, load or length change, the state and the serial output hold.
- R10: The wrap flag is high for exactly the one cycle after an advance brings the state back to its value at the last reset, load or length change. This happens exactly 2^n−1 advances after that start.
- R11: After reset the active-length bits are never all zero, and the bits above the active length are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_i | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Seed-load strobe |
| seed_i | input | 16 | Seed value |
| len_sel_i | input | 2 | Length select: 00=4, 01=8, 10/11=16 bits |
| step_i | input | 1 | Advance enable |
| bit_o | output | 1 | Serial output, last stage of active length |
| state_o | output | 16 | Full register state |
| wrap_o | output | 1 | One-cycle pulse on return to start state |

## Verification
Four controls compete for the same clock edge: reset, seed load, a length-select change and an advance. The bench drives them in pairs and in threes on one edge, for example load with step, reset with load, and a select change with step. A behavioural model applies the stated priority order and is compared with the outputs every cycle. A second collision involves the wrap pulse. A full-period run is cut by a load or length change before it wraps, and the bench checks that no stale wrap appears and that the period count restarts.

// File: rtl/lfsr_seq_pkg.sv
package lfsr_seq_pkg;
  localparam int unsigned SW = 16;
  localparam int unsigned CW = 16;

  typedef logic [SW-1:0] st_t;

  typedef enum logic [1:0] {
    LEN_4   = 2'b00,
    LEN_8   = 2'b01,
    LEN_16  = 2'b10,
    LEN_16B = 2'b11
  } len_sel_e;

  function automatic int unsigned len_bits(logic [1:0] sel);
    case (sel)
      2'b00:   return 4;
      2'b01:   return 8;
      default: return 16;
    endcase
  endfunction

  function automatic st_t len_mask(logic [1:0] sel);
    st_t m;
    m = '0;
    for (int i = 0; i < int'(SW); i++)
      if (i < int'(len_bits(sel))) m[i] = 1'b1;
    return m;
  endfunction

  // taps as zero-based stage indices
  function automatic st_t tap_mask(logic [1:0] sel);
    case (sel)
      2'b00:   return 16'h000C;  // stages 3,2
      2'b01:   return 16'h008E;  // stages 7,3,2,1
      default: return 16'h8805;  // stages 15,11,2,0
    endcase
  endfunction

  function automatic logic [CW-1:0] period(logic [1:0] sel);
    return CW'((32'd1 << len_bits(sel)) - 32'd1);
  endfunction
endpackage

// File: rtl/lfsr_tap_net.sv
module lfsr_tap_net
  import lfsr_seq_pkg::*;
#(
  parameter int unsigned W = SW
) (
  input  logic [W-1:0] state_i,
  input  logic [W-1:0] taps_i,
  output logic         fb_o
);
  // serial chain of two-input XORs over the tapped stages
  logic [W:0] chain;
  assign chain[0] = 1'b0;

  genvar g;
  generate
    for (g = 0; g < int'(W); g++) begin : g_xor
      assign chain[g+1] = chain[g] ^ (state_i[g] & taps_i[g]);
    end
  endgenerate

  assign fb_o = chain[W];
endmodule

// File: rtl/lfsr_seed_prep.sv
module lfsr_seed_prep
  import lfsr_seq_pkg::*;
(
  input  st_t        seed_i,
  input  logic [1:0] sel_i,
  output st_t        seed_o,
  output logic       seed_zero_o
);
  st_t masked;
  assign masked      = seed_i & len_mask(sel_i);
  assign seed_zero_o = (masked == '0);
  assign seed_o      = seed_zero_o ? st_t'(1) : masked;
endmodule

// File: rtl/lfsr_period_track.sv
module lfsr_period_track
  import lfsr_seq_pkg::*;
(
  input  logic          clk_i,
  input  logic          restart_i,
  input  st_t           start_i,
  input  logic          adv_i,
  input  st_t           next_i,
  input  logic [1:0]    sel_i,
  output logic          wrap_o,
  output logic [CW-1:0] cnt_o
);
  st_t           start_q;
  logic [CW-1:0] cnt_q;
  logic          wrap_q;
  logic          hit_start;

  assign hit_start = adv_i && (next_i == start_q);

  always_ff @(posedge clk_i) begin
    if (restart_i) begin
      start_q <= start_i;
      cnt_q   <= '0;
      wrap_q  <= 1'b0;
    end else if (adv_i) begin
      wrap_q <= hit_start;
      cnt_q  <= hit_start ? '0 : cnt_q + 1'b1;
    end else begin
      wrap_q <= 1'b0;
    end
  end

  assign wrap_o = wrap_q;
  assign cnt_o  = cnt_q;

  // return to the start state only after a full period
  assert_wrap_period_R10: assert property (@(posedge clk_i) disable iff (restart_i)
    hit_start |-> (cnt_q + 1'b1 == period(sel_i)));

  // the counter never reaches a full period without wrapping
  assert_cnt_bound_R10: assert property (@(posedge clk_i) disable iff (restart_i)
    adv_i |-> (cnt_q < period(sel_i)));

  assert_wrap_single_R10: assert property (@(posedge clk_i)
    wrap_q |=> !wrap_q);
endmodule

// File: rtl/lfsr_seqgen.sv
module lfsr_seqgen
  import lfsr_seq_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_i,
  input  logic        load_i,
  input  logic [15:0] seed_i,
  input  logic [1:0]  len_sel_i,
  input  logic        step_i,
  output logic        bit_o,
  output logic [15:0] state_o,
  output logic        wrap_o
);
  st_t           state_q, state_d, shifted, seed_clean, start_val;
  logic [1:0]    len_q;
  logic          fb, seed_zero, len_chg;
  logic          ev_reset, ev_load, ev_lenchg, ev_step, restart;
  logic [CW-1:0] step_cnt;

  // event decode, in priority order
  assign len_chg   = (len_sel_i != len_q);
  assign ev_reset  = rst_i;
  assign ev_load   = !rst_i && load_i;
  assign ev_lenchg = !rst_i && !load_i && len_chg;
  assign ev_step   = !rst_i && !load_i && !len_chg && step_i;
  assign restart   = ev_reset || ev_load || ev_lenchg;

  lfsr_tap_net #(.W(SW)) u_taps (
    .state_i (state_q),
    .taps_i  (tap_mask(len_q)),
    .fb_o    (fb)
  );

  lfsr_seed_prep u_seed (
    .seed_i      (seed_i),
    .sel_i       (len_sel_i),
    .seed_o      (seed_clean),
    .seed_zero_o (seed_zero)
  );

  assign shifted   = {state_q[SW-2:0], fb} & len_mask(len_q);
  assign start_val = ev_load ? seed_clean : st_t'(1);

  always_comb begin
    state_d = state_q;
    if (restart)      state_d = start_val;
    else if (ev_step) state_d = shifted;
  end

  always_ff @(posedge clk_i) begin
    state_q <= state_d;
    if (restart) len_q <= len_sel_i;
  end

  lfsr_period_track u_track (
    .clk_i     (clk_i),
    .restart_i (restart),
    .start_i   (start_val),
    .adv_i     (ev_step),
    .next_i    (shifted),
    .sel_i     (len_q),
    .wrap_o    (wrap_o),
    .cnt_o     (step_cnt)
  );

  assign state_o = state_q;
  assign bit_o   = state_q[len_bits(len_q)-1];

  assert_reset_state_R5: assert property (@(posedge clk_i)
    rst_i |=> (state_q == 16'h0001 && !wrap_o));

  assert_no_zero_state_R11: assert property (@(posedge clk_i) disable iff (rst_i)
    ((state_q & len_mask(len_q)) != '0) && ((state_q & ~len_mask(len_q)) == '0));

  assert_zero_seed_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    (load_i && seed_zero) |=> (state_q == 16'h0001));

  assert_len_restart_R8: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && len_chg) |=> (state_q == 16'h0001 && len_q == $past(len_sel_i)));

  assert_hold_R9: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_i && !len_chg && !step_i) |=> ($stable(state_q) && $stable(bit_o)));

  assert_shift_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    ev_step |=> ((state_q >> 1) == ($past(state_q) & (len_mask(len_q) >> 1))));
endmodule

// File: tb/lfsr_seqgen_tb.sv
module lfsr_seqgen_tb;
  logic        clk = 1'b0;
  logic        rst_i = 1'b1;
  logic        load_i = 1'b0;
  logic [15:0] seed_i = '0;
  logic [1:0]  len_sel_i = 2'b00;
  logic        step_i = 1'b0;
  logic        bit_o;
  logic [15:0] state_o;
  logic        wrap_o;

  always #5 clk = ~clk;

  lfsr_seqgen u_dut (
    .clk_i(clk), .rst_i(rst_i), .load_i(load_i), .seed_i(seed_i),
    .len_sel_i(len_sel_i), .step_i(step_i),
    .bit_o(bit_o), .state_o(state_o), .wrap_o(wrap_o)
  );

  int    n_tests = 0;
  int    n_fail  = 0;
  int    cycles  = 0;
  bit    chk_en  = 0;
  bit    done    = 0;
  string cur_req = "R5";
  int    wraps_seen = 0;

  // reference model state
  int m_sel = 0, m_state = 1, m_start = 1, m_steps = 0;
  bit m_wrap = 0;

  function automatic int ref_len(int sel);
    if (sel == 0) return 4;
    if (sel == 1) return 8;
    return 16;
  endfunction

  function automatic int ref_next(int st, int sel);
    int tp[$];
    int n, f;
    n = ref_len(sel);
    if (n == 4)      tp = '{4, 3};
    else if (n == 8) tp = '{8, 4, 3, 2};
    else             tp = '{16, 12, 3, 1};
    f = 0;
    foreach (tp[k]) f = f ^ ((st >> (tp[k] - 1)) & 1);
    return ((st * 2) + f) % (1 << n);
  endfunction

  task automatic check(bit ok, string req, string what, int act, int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    int s;
    cycles++;
    if (rst_i) begin
      m_sel = len_sel_i; m_state = 1; m_start = 1; m_steps = 0; m_wrap = 0;
    end else if (load_i) begin
      m_sel = len_sel_i;
      s = seed_i % (1 << ref_len(m_sel));
      if (s == 0) s = 1;
      m_state = s; m_start = s; m_steps = 0; m_wrap = 0;
    end else if (int'(len_sel_i) != m_sel) begin
      m_sel = len_sel_i; m_state = 1; m_start = 1; m_steps = 0; m_wrap = 0;
    end else if (step_i) begin
      m_state = ref_next(m_state, m_sel);
      m_steps++;
      m_wrap = (m_state == m_start);
      if (m_wrap) begin
        check(m_steps == (1 << ref_len(m_sel)) - 1, "R10", "period length",
              m_steps, (1 << ref_len(m_sel)) - 1);
        m_steps = 0;
      end
    end else begin
      m_wrap = 0;
    end
  end

  always @(negedge clk) begin
    if (chk_en) begin
      check(int'(state_o) == m_state, cur_req, "state", state_o, m_state);
      check(int'(bit_o) == ((m_state >> (ref_len(m_sel) - 1)) & 1), "R4", "serial bit",
            bit_o, (m_state >> (ref_len(m_sel) - 1)) & 1);
      check(wrap_o == m_wrap, "R10", "wrap flag", wrap_o, m_wrap);
      check(state_o != 16'h0 && (int'(state_o) >> ref_len(m_sel)) == 0, "R11",
            "nonzero / upper bits", state_o, m_state);
      if (wrap_o) wraps_seen++;
    end
  end

  always @(posedge clk) begin
    if (cycles > 190000 && !done) begin
      n_fail++;
      n_tests++;
      $display("FAIL watchdog: actual=%0d cycles expected<190000", cycles);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic run_steps(int n, string req);
    cur_req = req;
    step_i = 1'b1;
    tick(n);
    step_i = 1'b0;
  endtask

  initial begin
    tick(2);
    rst_i = 1'b0;
    chk_en = 1;
    check(state_o == 16'h0001 && !wrap_o, "R5", "reset state", state_o, 1);

    // R1: 4-bit full periods, two wraps expected in 30 advances
    wraps_seen = 0;
    run_steps(30, "R1");
    tick(1);
    check(wraps_seen == 2, "R1", "wrap count 4-bit", wraps_seen, 2);

    // R9: step low holds
    cur_req = "R9";
    tick(5);

    // R6: seed masking and zero replacement
    cur_req = "R6";
    seed_i = 16'hFFFF; load_i = 1'b1; tick(1); load_i = 1'b0; tick(1);
    check(state_o == 16'h000F, "R6", "masked seed", state_o, 16'h000F);
    seed_i = 16'hFFF0; load_i = 1'b1; tick(1); load_i = 1'b0; tick(1);
    check(state_o == 16'h0001, "R6", "zero seed replaced", state_o, 1);

    // R8: length change with step high restarts at 1
    cur_req = "R8";
    len_sel_i = 2'b01; step_i = 1'b1; tick(1); step_i = 1'b0; tick(1);
    check(state_o == 16'h0001, "R8", "length change", state_o, 1);

    // R2: 8-bit full period
    wraps_seen = 0;
    run_steps(260, "R2");
    tick(1);
    check(wraps_seen == 1, "R2", "wrap count 8-bit", wraps_seen, 1);

    // R7: load beats step; reset beats load; load beats length change
    cur_req = "R7";
    seed_i = 16'h00A5; load_i = 1'b1; step_i = 1'b1; tick(1);
    load_i = 1'b0; step_i = 1'b0; tick(1);
    check(state_o == 16'h00A5, "R7", "load over step", state_o, 16'h00A5);
    run_steps(40, "R7");
    rst_i = 1'b1; load_i = 1'b1; seed_i = 16'h0033; tick(1);
    rst_i = 1'b0; load_i = 1'b0; tick(1);
    check(state_o == 16'h0001, "R7", "reset over load", state_o, 1);
    len_sel_i = 2'b00; load_i = 1'b1; seed_i = 16'h0009; step_i = 1'b1; tick(1);
    load_i = 1'b0; step_i = 1'b0; tick(1);
    check(state_o == 16'h0009, "R7", "load with new length", state_o, 9);

    // R10: interrupt a run by a load before the wrap, no stale pulse
    wraps_seen = 0;
    run_steps(10, "R10");
    seed_i = 16'h0006; load_i = 1'b1; tick(1); load_i = 1'b0;
    run_steps(15, "R10");
    tick(1);
    check(wraps_seen == 1, "R10", "wrap after reload", wraps_seen, 1);

    // R3: 16-bit full period with a seed, select 2'b10
    len_sel_i = 2'b10; seed_i = 16'hACE1; load_i = 1'b1; tick(1); load_i = 1'b0;
    wraps_seen = 0;
    run_steps(65540, "R3");
    tick(1);
    check(wraps_seen == 1, "R3", "wrap count 16-bit", wraps_seen, 1);

    // R3: select 2'b11 also 16-bit; change of code restarts per R8
    len_sel_i = 2'b11; tick(1);
    run_steps(100, "R3");
    cur_req = "R9"; tick(4);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule